// File: doc/BRIEF.md
# Clock Divider Tree with Bypass and Tri-State Control

This block sits behind a clock oscillator and turns its fast clock into a set of related clocks. It produces a double-rate clock, five identical base-rate clocks, one base-rate clock of opposite phase, a half-rate clock, and a registered lock flag. A frequency-select input places an extra divide-by-two stage in the path. A bypass input replaces the oscillator with an external test clock. In bypass mode every clock output takes the polarity opposite to the one it has in normal operation.

An active-low enable/reset input acts at once, without waiting for a clock edge. While it is low, every output floats and the divider state is held at zero. When it is released, the base-rate and half-rate clocks start low. Both rise on the first edge of the internal clock. The oscillator and the loop that steers it are outside this block. The lock flag is a registered copy of a status input.

Top module: `clkdiv_tree`

## Requirements
- R1: The five base-rate outputs always carry the same level. `base_n_q` is always their logical complement.
- R2: With `freq_sel` high, the base-rate outputs have a period of two internal-clock periods. `dbl_q` follows the internal clock level.
- R3: With `freq_sel` low, the base-rate outputs have a period of four internal-clock periods. `dbl_q` has a period of two internal-clock periods and is high after the 1st, 3rd, 5th ... internal rising edge.
- R4: `half_q` has twice the period of the base-rate outputs. After release from reset, both start low, both rise on the first internal rising edge, and `half_q` changes only on rising edges of the base rate.
- R5: With `pll_en` high the internal clock is `osc_clk`. With `pll_en` low it is `sync_clk`.
- R6: With `pll_en` low, `dbl_q`, `base_q`, `base_n_q` and `half_q` are the complement of their normal-mode levels. `lock_q` is not inverted.
- R7: While `oe_rst_n` is low, all outputs, `lock_q` included, are high impedance. This takes effect without a clock edge. The divider state is cleared, so after release the outputs begin at their reset levels.
- R8: `lock_q` equals `lock_in` as sampled at the most recent internal rising edge, and is 0 before the first edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock, used when `pll_en` is high |
| sync_clk | input | 1 | Test clock, used when `pll_en` is low |
| pll_en | input | 1 | 1 = normal mode, 0 = bypass with inverted outputs |
| freq_sel | input | 1 | 0 = insert the extra divide-by-two stage |
| oe_rst_n | input | 1 | Active-low output enable and divider reset, asynchronous |
| lock_in | input | 1 | Lock status from the loop |
| dbl_q | output | 1 | Double-rate clock |
| base_q | output | NUM_BASE | Base-rate clocks |
| base_n_q | output | 1 | Complementary base-rate clock |
| half_q | output | 1 | Half-rate clock |
| lock_q | output | 1 | Registered lock status |

## Verification
The divider is run in all four combinations of `freq_sel` and `pll_en`. These runs tell the divide-by-2 tap from the divide-by-4 tap and the oscillator from the test clock, whose periods differ. They also separate a true polarity flip from a phase shift. A reset is applied in the middle of a count to show that the counter always restarts from zero and not from where it stopped. `lock_in` changes between edges, which shows that `lock_q` is registered and not a wire. The bench drives two copies of the block, one on pulled-up nets and one on pulled-down nets. Outputs that disagree between the two copies show high impedance, which a single net cannot show.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

  localparam int CNT_W = 3;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic dbl;
    logic base;
    logic half;
  } tap_lvls_t;

  // base tap: /2 of internal clock when fs high, /4 when fs low
  function automatic logic tap_base(cnt_t c, logic fs);
    return fs ? c[0] : c[1];
  endfunction

  // half tap: one stage further than base
  function automatic logic tap_half(cnt_t c, logic fs);
    return fs ? c[1] : c[2];
  endfunction

  // double tap: internal clock itself, or its /2 when prescaled
  function automatic logic tap_dbl(cnt_t c, logic fs, logic clk);
    return fs ? clk : c[0];
  endfunction

  function automatic tap_lvls_t flip_lvls(tap_lvls_t l, logic bypass);
    tap_lvls_t r;
    r.dbl  = l.dbl  ^ bypass;
    r.base = l.base ^ bypass;
    r.half = l.half ^ bypass;
    return r;
  endfunction

endpackage

// File: rtl/clkdiv_src_sel.sv
`timescale 1ns/1ps
module clkdiv_src_sel (
  input  logic osc_clk,
  input  logic sync_clk,
  input  logic pll_en,
  output logic clk_out
);
  always_comb begin
    clk_out = pll_en ? osc_clk : sync_clk;
  end
endmodule

// File: rtl/clkdiv_counter.sv
`timescale 1ns/1ps
module clkdiv_counter
  import clkdiv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output cnt_t cnt
);
  // Down counter: from zero the first step sets every bit, so all taps rise together
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/clkdiv_drv.sv
`timescale 1ns/1ps
module clkdiv_drv #(
  parameter int W = 1
) (
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign q[i] = en ? d[i] : 1'bz;
  end
endmodule

// File: rtl/clkdiv_tree.sv
`timescale 1ns/1ps
module clkdiv_tree
  import clkdiv_pkg::*;
#(
  parameter int NUM_BASE = 5
) (
  input  logic                osc_clk,
  input  logic                sync_clk,
  input  logic                pll_en,
  input  logic                freq_sel,
  input  logic                oe_rst_n,
  input  logic                lock_in,
  output logic                dbl_q,
  output logic [NUM_BASE-1:0] base_q,
  output logic                base_n_q,
  output logic                half_q,
  output logic                lock_q
);
  logic      clk_int;
  cnt_t      cnt;
  tap_lvls_t lvl_raw;
  tap_lvls_t lvl_out;
  logic      lvl_base;
  logic      lvl_half;
  logic      drive_en;
  logic      bypass;
  logic      lock_reg;

  clkdiv_src_sel u_sel (
    .osc_clk (osc_clk),
    .sync_clk(sync_clk),
    .pll_en  (pll_en),
    .clk_out (clk_int)
  );

  clkdiv_counter u_cnt (
    .clk  (clk_int),
    .rst_n(oe_rst_n),
    .cnt  (cnt)
  );

  always_comb begin
    bypass       = ~pll_en;
    drive_en     = oe_rst_n;
    lvl_raw.dbl  = tap_dbl(cnt, freq_sel, clk_int);
    lvl_raw.base = tap_base(cnt, freq_sel);
    lvl_raw.half = tap_half(cnt, freq_sel);
    lvl_base     = lvl_raw.base;
    lvl_half     = lvl_raw.half;
    lvl_out      = flip_lvls(lvl_raw, bypass);
  end

  always_ff @(posedge clk_int or negedge oe_rst_n) begin
    if (!oe_rst_n) lock_reg <= 1'b0;
    else           lock_reg <= lock_in;
  end

  clkdiv_drv #(.W(NUM_BASE)) u_drv_base (
    .en(drive_en), .d({NUM_BASE{lvl_out.base}}), .q(base_q)
  );
  clkdiv_drv #(.W(1)) u_drv_inv (
    .en(drive_en), .d(~lvl_out.base), .q(base_n_q)
  );
  clkdiv_drv #(.W(1)) u_drv_dbl (
    .en(drive_en), .d(lvl_out.dbl), .q(dbl_q)
  );
  clkdiv_drv #(.W(1)) u_drv_half (
    .en(drive_en), .d(lvl_out.half), .q(half_q)
  );
  clkdiv_drv #(.W(1)) u_drv_lock (
    .en(drive_en), .d(lock_reg), .q(lock_q)
  );
endmodule

// File: rtl/clkdiv_tree_chk.sv
`timescale 1ns/1ps
module clkdiv_tree_chk
  import clkdiv_pkg::*;
#(
  parameter int NUM_BASE = 5
) (
  input logic                clk_int,
  input logic                oe_rst_n,
  input logic                lock_in,
  input logic                lock_reg,
  input cnt_t                cnt,
  input logic                lvl_base,
  input logic                lvl_half,
  input logic [NUM_BASE-1:0] base_q,
  input logic                base_n_q
);
  p_base_match_r1: assert property (@(posedge clk_int) disable iff (!oe_rst_n)
    base_q == {NUM_BASE{base_q[0]}});

  p_inv_pair_r1: assert property (@(posedge clk_int) disable iff (!oe_rst_n)
    base_n_q == ~base_q[0]);

  p_half_step_r4: assert property (@(posedge clk_int) disable iff (!oe_rst_n)
    (lvl_half != $past(lvl_half)) |-> $rose(lvl_base));

  p_clear_r7: assert property (@(posedge clk_int)
    !oe_rst_n |-> cnt == '0);

  p_lock_copy_r8: assert property (@(posedge clk_int) disable iff (!oe_rst_n)
    1'b1 |=> lock_reg == $past(lock_in));
endmodule

bind clkdiv_tree clkdiv_tree_chk #(.NUM_BASE(NUM_BASE)) i_chk (
  .clk_int (clk_int),
  .oe_rst_n(oe_rst_n),
  .lock_in (lock_in),
  .lock_reg(lock_reg),
  .cnt     (cnt),
  .lvl_base(lvl_base),
  .lvl_half(lvl_half),
  .base_q  (base_q),
  .base_n_q(base_n_q)
);

// File: tb/test_clkdiv_tree.sv
`timescale 1ns/1ps
module test_clkdiv_tree;
  localparam int NB = 5;

  logic osc_clk = 1'b0;
  logic sync_clk = 1'b0;
  logic pll_en = 1'b1;
  logic freq_sel = 1'b1;
  logic oe_rst_n = 1'b1;
  logic lock_in = 1'b0;
  bit   done = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;

  // pulled-up copy
  tri1          dbl_h, inv_h, half_h, lock_h;
  tri1 [NB-1:0] base_h;
  // pulled-down copy
  tri0          dbl_l, inv_l, half_l, lock_l;
  tri0 [NB-1:0] base_l;

  always #2 osc_clk = ~osc_clk;     // 250 MHz
  initial begin
    #1;
    forever #5 sync_clk = ~sync_clk;
  end

  clkdiv_tree #(.NUM_BASE(NB)) i_clkdiv_tree (
    .osc_clk(osc_clk), .sync_clk(sync_clk), .pll_en(pll_en), .freq_sel(freq_sel),
    .oe_rst_n(oe_rst_n), .lock_in(lock_in),
    .dbl_q(dbl_h), .base_q(base_h), .base_n_q(inv_h), .half_q(half_h), .lock_q(lock_h)
  );

  clkdiv_tree #(.NUM_BASE(NB)) i_clkdiv_tree_lo (
    .osc_clk(osc_clk), .sync_clk(sync_clk), .pll_en(pll_en), .freq_sel(freq_sel),
    .oe_rst_n(oe_rst_n), .lock_in(lock_in),
    .dbl_q(dbl_l), .base_q(base_l), .base_n_q(inv_l), .half_q(half_l), .lock_q(lock_l)
  );

  task automatic chk(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // a floating output reads 1 on the pulled-up copy and 0 on the pulled-down copy
  task automatic chk_z(string tag, logic hi, logic lo);
    n_cmp++;
    if (!(hi === 1'b1 && lo === 1'b0)) begin
      n_bad++;
      $display("FAIL %s (float) t=%0t actual=%b/%b expected=1/0", tag, $time, hi, lo);
    end
  endtask

  task automatic chk_all_z(string tag);
    chk_z({tag, " dbl"}, dbl_h, dbl_l);
    for (int i = 0; i < NB; i++) chk_z({tag, " base"}, base_h[i], base_l[i]);
    chk_z({tag, " inv"}, inv_h, inv_l);
    chk_z({tag, " half"}, half_h, half_l);
    chk_z({tag, " lock"}, lock_h, lock_l);
  endtask

  task automatic wait_edge(logic use_osc);
    if (use_osc) @(posedge osc_clk);
    else         @(posedge sync_clk);
  endtask

  // Reference: edge k (k>=1) counted from release; base period P edges, high for the first half
  task automatic compare(int k, logic fs, logic pe, logic clk_lvl, logic lock_exp);
    int   p;
    logic e_base, e_half, e_dbl, flip;
    p      = fs ? 2 : 4;
    flip   = ~pe;
    e_base = (k >= 1) && (((k - 1) % p) < p / 2);
    e_half = (k >= 1) && (((k - 1) % (2 * p)) < p);
    e_dbl  = fs ? clk_lvl : ((k >= 1) && (((k - 1) % 2) == 0));
    e_base ^= flip;
    e_half ^= flip;
    e_dbl  ^= flip;
    for (int i = 0; i < NB; i++) begin
      chk(fs ? "R2 base" : "R3 base", base_h[i], e_base);
      chk("R1 base copy", base_l[i], e_base);
    end
    chk("R1 inverted", inv_h, ~e_base);
    chk("R1 inverted copy", inv_l, ~e_base);
    chk(fs ? "R2 dbl" : "R3 dbl", dbl_h, e_dbl);
    chk("R6 dbl copy", dbl_l, e_dbl);
    chk("R4 half", half_h, e_half);
    chk("R6 half copy", half_l, e_half);
    chk("R8 lock", lock_h, lock_exp);
    chk("R8 lock copy", lock_l, lock_exp);
  endtask

  // Enter reset (asynchronously), set the mode, release, then compare each edge
  task automatic run_mode(logic pe, logic fs, int n_edges);
    logic lock_exp;
    logic lock_cur;
    oe_rst_n = 1'b0;
    #0.5;
    chk_all_z("R7 async");
    pll_en   = pe;
    freq_sel = fs;
    wait_edge(pe);
    #1;
    chk_all_z("R7 held");
    oe_rst_n = 1'b1;
    #0.1;
    lock_exp = 1'b0;
    compare(0, fs, pe, 1'b1, lock_exp);   // R7: cleared start levels
    lock_cur = lock_in;
    for (int k = 1; k <= n_edges; k++) begin
      wait_edge(pe);
      lock_exp = lock_cur;
      #1;
      compare(k, fs, pe, 1'b1, lock_exp);
      lock_cur = ($urandom % 3) != 0;
      lock_in  = lock_cur;
    end
  endtask

  initial begin
    #0.2 oe_rst_n = 1'b0;
    #3;
    chk_all_z("R7 power-up");
    run_mode(1'b1, 1'b1, 40);   // R2 R5: oscillator, no prescale
    run_mode(1'b1, 1'b0, 40);   // R3: oscillator, prescaled
    run_mode(1'b1, 1'b1, 13);   // R7: stop mid-count
    run_mode(1'b0, 1'b1, 30);   // R5 R6: test clock, inverted
    run_mode(1'b0, 1'b0, 30);   // R6: test clock, prescaled, inverted
    run_mode(1'b1, 1'b0, 7);    // R7: restart after odd count
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule